// File: doc/BRIEF.md
# DRAM Refresh and Power-On Sequencer

This block keeps an asynchronous DRAM alive without help from the rest of the memory controller. After reset it waits out the power-up pause. It then runs a burst of wake-up refresh cycles and raises an init-done flag. From then on it schedules one CAS-before-RAS refresh per refresh interval. Each refresh is requested from an external arbiter, which answers with a grant. A granted refresh drives the strobe pins through the full CAS-first sequence. The pins return to idle before the block can ask again.

When the arbiter holds off refreshes, the block keeps count of the ones it owes and issues them back to back once it is granted. If the backlog grows past a threshold, the refresh deadline is treated as missed. Init-done drops and the whole wake-up burst is run again, with no second power-up pause. All timing is given in nanoseconds or microseconds together with the clock frequency in MHz, and the block turns these into cycle counts.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, `rfsh_req`, `rfsh_busy` and `init_done` are 0, and `ras_n` and `cas_n` are both 1.
- R2: For the first PAUSE_US*CLK_MHZ clock cycles after reset release, no request is raised and both strobes stay high. The first request appears exactly at that cycle.
- R3: After the pause, WAKE_N granted refresh cycles are performed. `init_done` rises one cycle after `rfsh_busy` falls at the end of the last of them.
- R4: `rfsh_req` is high only when no refresh is in progress and a refresh is owed. A cycle in which `rfsh_req` and `rfsh_gnt` are both high starts a refresh. `rfsh_busy` is then high for exactly CSR+RAS+RP cycles, starting with the next cycle.
- R5: Each refresh drives `cas_n` low with `ras_n` high for CSR cycles. It then drives `ras_n` low for RAS cycles. `cas_n` returns high after min(CHR, RAS) of those cycles. Both strobes are then high for RP cycles. RAS never falls while CAS is high. The cycle counts are the ceilings of CSR_NS, CHR_NS, RAS_NS and RP_NS times CLK_MHZ/1000, with a minimum of 1.
- R6: While `init_done` is high, one refresh becomes owed every REFI_NS*CLK_MHZ/1000 cycles. The owed count saturates at OWED_MAX.
- R7: Each started refresh reduces the owed count by one. Owed refreshes are issued back to back while grant stays high.
- R8: When the owed count exceeds OWED_THRESH, the request is withheld and `init_done` falls on the next cycle. The owed count is cleared, and WAKE_N wake-up refreshes are run again before `init_done` rises.
- R9: `rfsh_gnt` has no effect while `rfsh_req` is low, including during the power-up pause: `rfsh_busy` stays low.
- R10: Whenever `rfsh_busy` is low, `ras_n` and `cas_n` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| rfsh_gnt | input | 1 | Arbiter grant for the pending refresh |
| rfsh_req | output | 1 | Refresh request to the arbiter |
| rfsh_busy | output | 1 | A refresh sequence is driving the strobes |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| init_done | output | 1 | Wake-up done and periodic refresh running |

## Verification
The hardest condition to reach is the missed deadline. The grant must be denied across several refresh intervals, so that the backlog climbs past the threshold while the block still looks healthy. The stimulus does this by holding grant low for longer than threshold-plus-one intervals and then restoring it, which forces a complete second wake-up burst. A second instance has its threshold equal to its saturation limit. Its grant is withheld for many intervals, so the only trace the saturation leaves at the ports is the length of the refresh burst that follows.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {MODE_PAUSE, MODE_WAKE, MODE_RUN} mode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_PRE} phase_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
  import rfsh_pkg::*;
#(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned CHR_CYC = 1,
  parameter int unsigned RAS_CYC = 3,
  parameter int unsigned RP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned M1   = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int unsigned M2   = (RP_CYC > CHR_CYC) ? RP_CYC : CHR_CYC;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_SETUP;
        cnt_d   = '0;
      end
      PH_SETUP: if (cnt_q == CW'(CSR_CYC - 1)) begin
        phase_d = PH_ACTIVE;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_ACTIVE: if (cnt_q == CW'(RAS_CYC - 1)) begin
        phase_d = PH_PRE;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_PRE: if (cnt_q == CW'(RP_CYC - 1)) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy  = (phase_q != PH_IDLE);
  assign ras_n = (phase_q != PH_ACTIVE);
  assign cas_n = !((phase_q == PH_SETUP) ||
                   ((phase_q == PH_ACTIVE) && (cnt_q < CW'(CHR_CYC))));

  // R5: the row strobe falls only after the column strobe was already low
  assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  // R5: precharge follows every row strobe release
  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  // R5: column strobe is high again by the time RAS rises
  assert_cas_up_at_ras_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned REFI_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned TW = $clog2(REFI_CYC + 1);

  logic [TW-1:0] tmr_q, tmr_d;

  assign tick = en && (tmr_q == TW'(REFI_CYC - 1));

  always_comb begin
    if (!en)      tmr_d = '0;
    else if (tick) tmr_d = '0;
    else          tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned WAKE_N      = 8,
  parameter int unsigned OWED_MAX    = 9,
  parameter int unsigned OWED_THRESH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic busy,
  input  logic tick,
  output logic req,
  output logic start,
  output logic run,
  output logic init_done
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WAKE_N + 1);
  localparam int unsigned OW = $clog2(OWED_MAX + 1);

  mode_e         mode_q, mode_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [WW-1:0] wake_q, wake_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          overrun;

  assign overrun   = owed_q > OW'(OWED_THRESH);
  assign req       = !busy && (((mode_q == MODE_WAKE) && (wake_q != '0)) ||
                               ((mode_q == MODE_RUN) && (owed_q != '0) && !overrun));
  assign start     = req && gnt;
  assign run       = (mode_q == MODE_RUN);
  assign init_done = run;

  always_comb begin
    mode_d  = mode_q;
    pause_d = pause_q;
    wake_d  = wake_q;
    owed_d  = owed_q;
    case (mode_q)
      MODE_PAUSE: begin
        if (pause_q == PW'(PAUSE_CYC - 1)) begin
          mode_d = MODE_WAKE;
          wake_d = WW'(WAKE_N);
        end else pause_d = pause_q + 1'b1;
      end
      MODE_WAKE: begin
        if (start) wake_d = wake_q - 1'b1;
        else if ((wake_q == '0) && !busy) begin
          mode_d = MODE_RUN;
          owed_d = '0;
        end
      end
      MODE_RUN: begin
        if (overrun) begin
          mode_d = MODE_WAKE;
          wake_d = WW'(WAKE_N);
          owed_d = '0;
        end else begin
          case ({tick, start})
            2'b10:   if (owed_q != OW'(OWED_MAX)) owed_d = owed_q + 1'b1;
            2'b01:   owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
          endcase
        end
      end
      default: mode_d = MODE_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
      owed_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      pause_q <= pause_d;
      wake_q  <= wake_d;
      owed_q  <= owed_d;
    end
  end

  // R2: nothing is started during the power-up pause
  assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAUSE) |-> !start);
  // R6: backlog never passes its saturation limit
  assert_owed_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(OWED_MAX));
  // R8: a backlog past the threshold restarts the wake-up burst
  assert_overrun_rewake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_RUN) && overrun) |=> ((mode_q == MODE_WAKE) && (wake_q == WW'(WAKE_N))));
  // R3: init-done only rises once the wake-up burst is spent
  assert_init_after_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(mode_q == MODE_WAKE) && $past(wake_q == '0)));
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned PAUSE_US    = 200,
  parameter int unsigned REFI_NS     = 15600,
  parameter int unsigned WAKE_N      = 8,
  parameter int unsigned OWED_MAX    = 9,
  parameter int unsigned OWED_THRESH = 8,
  parameter int unsigned CSR_NS      = 10,
  parameter int unsigned CHR_NS      = 10,
  parameter int unsigned RAS_NS      = 60,
  parameter int unsigned RP_NS       = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic rfsh_busy,
  output logic ras_n,
  output logic cas_n,
  output logic init_done
);
  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int unsigned REFI_CYC  = REFI_NS * CLK_MHZ / 1000;
  localparam int unsigned CSR_CYC   = ns_to_cyc(CSR_NS, CLK_MHZ);
  localparam int unsigned CHR_CYC   = ns_to_cyc(CHR_NS, CLK_MHZ);
  localparam int unsigned RAS_CYC   = ns_to_cyc(RAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC    = ns_to_cyc(RP_NS, CLK_MHZ);

  logic start, run, tick;

  rfsh_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N),
    .OWED_MAX(OWED_MAX), .OWED_THRESH(OWED_THRESH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gnt(rfsh_gnt), .busy(rfsh_busy), .tick(tick),
    .req(rfsh_req), .start(start), .run(run), .init_done(init_done)
  );

  rfsh_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  rfsh_cbr_engine #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(rfsh_busy), .ras_n(ras_n), .cas_n(cas_n)
  );

  // R4: a granted request opens the sequence with CAS low and RAS high
  assert_grant_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && rfsh_gnt) |=> (rfsh_busy && !cas_n && ras_n));
  // R9: grant without request leaves the strobes idle
  assert_grant_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfsh_req && !rfsh_busy) |=> !rfsh_busy);
endmodule

// File: tb/sim_dram_rfsh_seq.sv
`timescale 1ns/1ps
module sim_dram_rfsh_seq;
  localparam int MHZ = 50;
  localparam int PAUSE_C = 2 * MHZ;
  localparam int REFI_C  = 1000 * MHZ / 1000;
  localparam int WAKE    = 8;
  localparam int OMAX    = 6;
  localparam int OTHR    = 4;
  localparam int C_CSR   = (30 * MHZ + 999) / 1000;
  localparam int C_CHR   = (30 * MHZ + 999) / 1000;
  localparam int C_RAS   = (80 * MHZ + 999) / 1000;
  localparam int C_RP    = (40 * MHZ + 999) / 1000;
  localparam int C_TOT   = C_CSR + C_RAS + C_RP;
  localparam int C_CASLO = C_CSR + ((C_CHR < C_RAS) ? C_CHR : C_RAS);

  logic clk, rst_n, gnt, gnt1;
  logic req, busy, ras_n, cas_n, init_done;
  logic req1, busy1, ras1, cas1, init1;

  initial clk = 0;
  always #10 clk = ~clk;

  dram_rfsh_seq #(.CLK_MHZ(MHZ), .PAUSE_US(2), .REFI_NS(1000), .WAKE_N(WAKE),
    .OWED_MAX(OMAX), .OWED_THRESH(OTHR), .CSR_NS(30), .CHR_NS(30), .RAS_NS(80), .RP_NS(40))
  u0 (.clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(req), .rfsh_busy(busy),
      .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done));

  dram_rfsh_seq #(.CLK_MHZ(MHZ), .PAUSE_US(2), .REFI_NS(4000), .WAKE_N(WAKE),
    .OWED_MAX(3), .OWED_THRESH(3), .CSR_NS(30), .CHR_NS(30), .RAS_NS(80), .RP_NS(40))
  u1 (.clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt1), .rfsh_req(req1), .rfsh_busy(busy1),
      .ras_n(ras1), .cas_n(cas1), .init_done(init1));

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0, u1_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // reference model: 0 pause, 1 wake, 2 run; eng = cycles into refresh, -1 idle
  int m_mode, m_pause, m_wake, m_owed, m_tmr, m_eng;

  function automatic bit m_req();
    if (m_eng >= 0) return 0;
    if (m_mode == 1) return m_wake > 0;
    if (m_mode == 2) return (m_owed > 0) && (m_owed <= OTHR);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pause = 0; m_wake = 0; m_owed = 0; m_tmr = 0; m_eng = -1;
    end else begin
      bit st, tk, was_busy;
      st = m_req() && gnt;
      tk = (m_mode == 2) && (m_tmr == REFI_C - 1);
      was_busy = (m_eng >= 0);
      if (m_eng >= 0) begin
        m_eng++;
        if (m_eng == C_TOT) m_eng = -1;
      end
      if (st) m_eng = 0;
      if (m_mode == 0) begin
        m_pause++;
        if (m_pause == PAUSE_C) begin m_mode = 1; m_wake = WAKE; end
      end else if (m_mode == 1) begin
        if (st) m_wake--;
        else if (m_wake == 0 && !was_busy) begin m_mode = 2; m_owed = 0; m_tmr = -1; end
      end else begin
        if (m_owed > OTHR) begin m_mode = 1; m_wake = WAKE; m_owed = 0; end
        else begin
          if (tk && !st && m_owed < OMAX) m_owed++;
          if (st && !tk) m_owed--;
        end
      end
      if (m_mode == 2) m_tmr = tk ? 0 : m_tmr + 1;
      else m_tmr = 0;
      cyc++;
    end
  end

  // per-cycle comparison and port monitors
  int first_req = -1, pre_init_ras = 0, rasonly = 0, idle_viol = 0, pause_busy = 0;
  int rewake_ras = 0, rewakes = 0;
  bit seen_init = 0, rewake_on = 0, p_ras = 1, p_init = 0;

  always @(negedge clk) if (rst_n && !finished) begin
    bit e_busy, e_ras, e_cas;
    e_busy = (m_eng >= 0);
    e_ras  = !(m_eng >= C_CSR && m_eng < C_CSR + C_RAS);
    e_cas  = !(m_eng >= 0 && m_eng < C_CASLO);
    chk(req == m_req(), "R4 R6 R7 req", req, m_req());
    chk(busy == e_busy, "R4 busy", busy, e_busy);
    chk(ras_n == e_ras, "R5 ras_n", ras_n, e_ras);
    chk(cas_n == e_cas, "R5 cas_n", cas_n, e_cas);
    chk(init_done == (m_mode == 2), "R3 R8 init_done", init_done, m_mode == 2);
    if (req && first_req < 0) first_req = cyc;
    if (cyc < PAUSE_C && busy) pause_busy++;
    if (!busy && (!ras_n || !cas_n)) idle_viol++;
    if (p_ras && !ras_n) begin
      if (cas_n) rasonly++;
      if (!seen_init) pre_init_ras++;
      if (rewake_on) rewake_ras++;
    end
    if (init_done) seen_init = 1;
    if (p_init && !init_done) begin rewake_on = 1; rewake_ras = 0; end
    if (!p_init && init_done && rewake_on) begin
      rewake_on = 0; rewakes++;
      chk(rewake_ras == WAKE, "R8 rewake count", rewake_ras, WAKE);
    end
    p_ras = ras_n; p_init = init_done;
  end

  always @(posedge clk) if (cyc > 20000 && !finished) begin
    finished = 1;
    errors++; checks++;
    $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // second instance: saturation of the backlog
  initial begin
    int c0, n;
    bit pr;
    gnt1 = 0;
    @(posedge rst_n);
    @(negedge clk); gnt1 = 1;
    while (!init1) @(negedge clk);
    c0 = cyc; gnt1 = 0;
    while (cyc < c0 + 2050) @(negedge clk);
    gnt1 = 1; n = 0; pr = ras1;
    repeat (100) begin
      @(negedge clk);
      if (pr && !ras1) n++;
      pr = ras1;
    end
    chk(n == 3, "R6 saturated burst", n, 3);
    u1_done = 1;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    rst_n = 0; gnt = 0;
    repeat (3) @(negedge clk);
    chk(req == 0, "R1 req", req, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ras_n == 1, "R1 ras_n", ras_n, 1);
    chk(cas_n == 1, "R1 cas_n", cas_n, 1);
    chk(init_done == 0, "R1 init_done", init_done, 0);
    rst_n = 1;
    for (int i = 0; i < PAUSE_C - 2; i++) begin @(negedge clk); gnt = ~gnt; end
    gnt = 1;
    repeat (600) @(negedge clk);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt = lfsr[0];
    end
    gnt = 0; repeat (400) @(negedge clk);
    gnt = 1; repeat (400) @(negedge clk);
    gnt = 0; repeat (120) @(negedge clk);
    gnt = 1; repeat (200) @(negedge clk);
    while (!u1_done) @(negedge clk);
    chk(first_req == PAUSE_C, "R2 first request cycle", first_req, PAUSE_C);
    chk(pre_init_ras == WAKE, "R3 wake refreshes", pre_init_ras, WAKE);
    chk(rewakes == 1, "R8 overrun rewake seen", rewakes, 1);
    chk(rasonly == 0, "R5 RAS fall with CAS high", rasonly, 0);
    chk(idle_viol == 0, "R10 strobes low while idle", idle_viol, 0);
    chk(pause_busy == 0, "R9 grant during pause", pause_busy, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule